// File: doc/BRIEF.md
# Not Recently Used Page Victim Selector

This block keeps two status flags for each of a fixed number of pages: a referenced flag and a modified flag. Read and write accesses are reported on two separate ports. A periodic tick, generated elsewhere, ages the pages by clearing every referenced flag. The modified flags stay until reset.

The two flags together place a page in one of four ranks. When a replacement decision is needed, the requester pulses a request line. One cycle later the block returns a page index from the lowest-ranked group that has any member. It also returns that page's modified flag, so the requester knows whether the page must be written back first.

Within the chosen group the page is picked pseudo-randomly. A free-running maximal-length shift register supplies a start position. A circular scan from that position returns the first page that belongs to the group.

Top module: `nru_victim_sel`

## Requirements
- R1: A read access (`rd_vld` high) sets the referenced flag of page `rd_page` at the next clock edge.
- R2: A write access (`wr_vld` high) sets both the referenced flag and the modified flag of page `wr_page` at the next clock edge.
- R3: A `tick` with no access in the same cycle clears the referenced flag of every page and leaves every modified flag unchanged.
- R4: When an access and a `tick` occur in the same cycle, the accessed page keeps its referenced flag set. Every other page loses its referenced flag.
- R5: The rank of a page is {referenced, modified} as a 2-bit number:
  - 0: not referenced, not modified
  - 1: modified only
  - 2: referenced only
  - 3: both flags set

  The victim always belongs to the lowest rank that has at least one page.
- R6: Within the chosen rank the victim is chosen pseudo-randomly. Repeated requests against unchanged flags, where the rank holds several pages, return more than one distinct index.
- R7: `victim_dirty` equals the modified flag of the returned page.
- R8: `victim_vld` is high exactly one cycle after a cycle with `req` high, and low otherwise. The victim is chosen from the flags as they stood in the request cycle, before that cycle's accesses or tick take effect.
- R9: Synchronous active-low reset clears all flags and `victim_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_vld | input | 1 | Read access strobe |
| rd_page | input | $clog2(NUM_PAGES) | Page index of the read access |
| wr_vld | input | 1 | Write access strobe |
| wr_page | input | $clog2(NUM_PAGES) | Page index of the write access |
| tick | input | 1 | Periodic aging pulse; clears all referenced flags |
| req | input | 1 | Victim request |
| victim_vld | output | 1 | Victim result valid, one cycle after `req` |
| victim_idx | output | $clog2(NUM_PAGES) | Index of the selected page |
| victim_dirty | output | 1 | Modified flag of the selected page |

## Verification
On every cycle, the assertions check that accesses set their flags, that a tick clears referenced flags while keeping modified flags, and that an access wins over a simultaneous tick. They also check the one-cycle response timing, that rank 0 is preferred whenever it is populated, and that the shift register never locks up at zero.

Some behaviours can only be shown by the bench's scenarios:
- that the chosen rank is the lowest populated one in all four cases;
- that a particular page was the only member of its rank, and so had to be returned;
- that the pick varies across repeated requests.

The bench covers these with per-page sweeps and a long stream of mixed traffic. Throughout, it compares every result against its own model of the flags.

// File: rtl/nru_pkg.sv
// Package nru_pkg
// Shared types for the victim selector: the four-level page rank.
// Assumes rank = {referenced, modified}, lower value evicted first.
package nru_pkg;
    typedef enum logic [1:0] {
        RANK_COLD_CLEAN = 2'd0,
        RANK_COLD_DIRTY = 2'd1,
        RANK_HOT_CLEAN  = 2'd2,
        RANK_HOT_DIRTY  = 2'd3
    } nru_rank_e;

    localparam int NUM_RANKS = 4;
endpackage

// File: rtl/nru_status_bits.sv
// Module nru_status_bits
// Holds one referenced flag and one modified flag per page.
// Accesses set flags; tick clears referenced flags; an access in the
// same cycle as a tick wins for the accessed page.
// Assumes page indices are below NUM_PAGES.
module nru_status_bits #(
    parameter int NUM_PAGES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_vld,
    input  logic [IDX_W-1:0]     rd_page,
    input  logic                 wr_vld,
    input  logic [IDX_W-1:0]     wr_page,
    input  logic                 tick,
    output logic [NUM_PAGES-1:0] ref_o,
    output logic [NUM_PAGES-1:0] mod_o
);
    logic [NUM_PAGES-1:0] ref_q;
    logic [NUM_PAGES-1:0] mod_q;

    for (genvar gi = 0; gi < NUM_PAGES; gi++) begin : g_page
        localparam logic [IDX_W-1:0] PID = gi[IDX_W-1:0];
        logic rd_hit;
        logic wr_hit;

        // decode whether this page is touched this cycle
        always_comb begin
            rd_hit = rd_vld && (rd_page == PID);
            wr_hit = wr_vld && (wr_page == PID);
        end

        // update the page's flags: access beats tick, modified is sticky
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_q[gi] <= 1'b0;
                mod_q[gi] <= 1'b0;
            end else begin
                if (rd_hit || wr_hit) begin
                    ref_q[gi] <= 1'b1;
                end else if (tick) begin
                    ref_q[gi] <= 1'b0;
                end
                if (wr_hit) begin
                    mod_q[gi] <= 1'b1;
                end
            end
        end
    end

    assign ref_o = ref_q;
    assign mod_o = mod_q;

    // R1
    rd_sets_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> ref_q[$past(rd_page)]);

    // R2
    wr_sets_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> (ref_q[$past(wr_page)] && mod_q[$past(wr_page)]));

    // R3
    tick_clears_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rd_vld && !wr_vld) |=> (ref_q == '0));

    // R3
    tick_keeps_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_vld) |=> $stable(mod_q));

    // R4
    access_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_vld) |=> ref_q[$past(rd_page)]);
endmodule

// File: rtl/nru_lfsr.sv
// Module nru_lfsr
// Free-running maximal-length Fibonacci shift register, seeded at reset.
// Assumes LFSR_W between 4 and 16; other widths fall back to 8-bit taps.
module nru_lfsr #(
    parameter int LFSR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state_o
);
    function automatic logic [31:0] tap_mask(input int w);
        case (w)
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0829;
            13:      return 32'h0000_100D;
            14:      return 32'h0000_2015;
            15:      return 32'h0000_6000;
            16:      return 32'h0000_D008;
            default: return 32'h0000_00B8;
        endcase
    endfunction

    localparam logic [31:0]       TAPS32 = tap_mask(LFSR_W);
    localparam logic [LFSR_W-1:0] TAPS   = TAPS32[LFSR_W-1:0];
    localparam logic [LFSR_W-1:0] SEED   = {{(LFSR_W-1){1'b0}}, 1'b1};

    logic [LFSR_W-1:0] state_q;
    logic              fb;

    // feedback bit from the tapped positions
    always_comb fb = ^(state_q & TAPS);

    // advance the register every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= {state_q[LFSR_W-2:0], fb};
    end

    assign state_o = state_q;

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q != '0));
endmodule

// File: rtl/nru_rank_pick.sv
// Module nru_rank_pick
// Combinational victim choice: forms the four rank masks, selects the
// lowest populated rank and scans it circularly from start_i.
// Assumes start_i < NUM_PAGES.
module nru_rank_pick
    import nru_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_PAGES-1:0] ref_i,
    input  logic [NUM_PAGES-1:0] mod_i,
    input  logic [IDX_W-1:0]     start_i,
    output logic [IDX_W-1:0]     pick_o,
    output nru_rank_e            rank_o
);
    logic [NUM_PAGES-1:0] rank_mask [NUM_RANKS];
    logic [NUM_PAGES-1:0] sel_mask;

    for (genvar gr = 0; gr < NUM_RANKS; gr++) begin : g_rank
        localparam logic [1:0] RC = gr[1:0];
        // members of this rank
        always_comb rank_mask[gr] = (RC[1] ? ref_i : ~ref_i) & (RC[0] ? mod_i : ~mod_i);
    end

    // choose the lowest rank with at least one member
    always_comb begin
        rank_o   = RANK_HOT_DIRTY;
        sel_mask = rank_mask[NUM_RANKS-1];
        for (int r = NUM_RANKS - 1; r >= 0; r--) begin
            if (|rank_mask[r]) begin
                rank_o   = nru_rank_e'(r[1:0]);
                sel_mask = rank_mask[r];
            end
        end
    end

    // circular scan from the random start for the first member
    always_comb begin
        logic found;
        int   pos;
        found  = 1'b0;
        pick_o = '0;
        for (int k = 0; k < NUM_PAGES; k++) begin
            pos = int'(start_i) + k;
            if (pos >= NUM_PAGES) pos = pos - NUM_PAGES;
            if (!found && sel_mask[pos]) begin
                found  = 1'b1;
                pick_o = pos[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/nru_victim_sel.sv
// Module nru_victim_sel
// Top of the not-recently-used victim selector. Tracks per-page flags,
// and on req registers a victim index and its modified flag, valid one
// cycle later. The pick uses the flags before this cycle's updates.
// Assumes NUM_PAGES >= 2 and LFSR_W >= $clog2(NUM_PAGES).
module nru_victim_sel
    import nru_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int LFSR_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_vld,
    input  logic [$clog2(NUM_PAGES)-1:0] rd_page,
    input  logic                         wr_vld,
    input  logic [$clog2(NUM_PAGES)-1:0] wr_page,
    input  logic                         tick,
    input  logic                         req,
    output logic                         victim_vld,
    output logic [$clog2(NUM_PAGES)-1:0] victim_idx,
    output logic                         victim_dirty
);
    localparam int IDX_W = $clog2(NUM_PAGES);

    logic [NUM_PAGES-1:0] ref_w;
    logic [NUM_PAGES-1:0] mod_w;
    logic [LFSR_W-1:0]    lfsr_w;
    logic [IDX_W-1:0]     start_w;
    logic [IDX_W-1:0]     pick_w;
    nru_rank_e            rank_w;

    logic                 vld_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 dirty_q;

    nru_status_bits #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_vld  (rd_vld),
        .rd_page (rd_page),
        .wr_vld  (wr_vld),
        .wr_page (wr_page),
        .tick    (tick),
        .ref_o   (ref_w),
        .mod_o   (mod_w)
    );

    nru_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (lfsr_w)
    );

    // fold the random state into a legal start position
    always_comb start_w = IDX_W'(int'(lfsr_w) % NUM_PAGES);

    nru_rank_pick #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_pick (
        .ref_i   (ref_w),
        .mod_i   (mod_w),
        .start_i (start_w),
        .pick_o  (pick_w),
        .rank_o  (rank_w)
    );

    // register the victim result on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            idx_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            vld_q <= req;
            if (req) begin
                idx_q   <= pick_w;
                dirty_q <= mod_w[pick_w];
            end
        end
    end

    assign victim_vld   = vld_q;
    assign victim_idx   = idx_q;
    assign victim_dirty = dirty_q;

    // R8
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> victim_vld);

    // R8
    no_resp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !victim_vld);

    // R5
    cold_clean_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (|(~ref_w & ~mod_w))) |-> (!ref_w[pick_w] && !mod_w[pick_w]));

    // R5
    rank_matches_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (rank_w == nru_rank_e'({ref_w[pick_w], mod_w[pick_w]})));
endmodule

// File: tb/nru_victim_sel_tb.sv
module nru_victim_sel_tb;
    localparam int N      = 8;
    localparam int IW     = 3;
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_vld = 1'b0, wr_vld = 1'b0, tick = 1'b0, req = 1'b0;
    logic [IW-1:0] rd_page = '0, wr_page = '0;
    logic          victim_vld, victim_dirty;
    logic [IW-1:0] victim_idx;

    logic [N-1:0]  ref_m, mod_m, snap_ref, snap_mod;
    int            checks = 0, errors = 0;
    int            exp_rank;
    logic [31:0]   seed = 32'h1234_5678;

    always #(CLK_NS / 2) clk = ~clk;

    nru_victim_sel #(.NUM_PAGES(N), .LFSR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_page(rd_page),
        .wr_vld(wr_vld), .wr_page(wr_page), .tick(tick), .req(req),
        .victim_vld(victim_vld), .victim_idx(victim_idx), .victim_dirty(victim_dirty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int min_rank(input logic [N-1:0] r, input logic [N-1:0] m);
        int best = 3;
        for (int p = 0; p < N; p++)
            if (int'({r[p], m[p]}) < best) best = int'({r[p], m[p]});
        return best;
    endfunction

    // one cycle of stimulus, driven at a falling edge; checks the response
    task automatic cyc(input bit rv, input int rp, input bit wv, input int wp,
                       input bit tk, input bit rq);
        rd_vld = rv; rd_page = IW'(rp); wr_vld = wv; wr_page = IW'(wp);
        tick = tk; req = rq;
        if (rq) begin
            snap_ref = ref_m; snap_mod = mod_m;
            exp_rank = min_rank(ref_m, mod_m);
        end
        for (int p = 0; p < N; p++) begin
            if (tk) ref_m[p] = 1'b0;
            if ((rv && rp == p) || (wv && wp == p)) ref_m[p] = 1'b1;
            if (wv && wp == p) mod_m[p] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        rd_vld = 0; wr_vld = 0; tick = 0; req = 0;
        if (rq) begin
            chk(victim_vld === 1'b1, "R8 valid after req", int'(victim_vld), 1);
            chk(int'({snap_ref[victim_idx], snap_mod[victim_idx]}) == exp_rank,
                "R5 lowest rank", int'({snap_ref[victim_idx], snap_mod[victim_idx]}), exp_rank);
            chk(victim_dirty == snap_mod[victim_idx], "R7 dirty flag",
                int'(victim_dirty), int'(snap_mod[victim_idx]));
        end else begin
            chk(victim_vld === 1'b0, "R8 idle valid", int'(victim_vld), 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        ref_m = '0; mod_m = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] seen;
        @(negedge clk);
        do_reset();
        // R9: reset state
        chk(victim_vld === 1'b0, "R9 reset valid", int'(victim_vld), 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk(victim_dirty == 1'b0, "R9 reset dirty", int'(victim_dirty), 0);

        // R6: unchanged all-cold state, repeated requests vary
        seen = '0;
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 0, 0, 0, 1);
            seen[victim_idx] = 1'b1;
        end
        chk($countones(seen) >= 2, "R6 distinct picks", $countones(seen), 2);

        // R1: read every page but k, k must be the victim
        for (int k = 0; k < N; k++) begin
            cyc(0, 0, 0, 0, 1, 0);
            for (int p = 0; p < N; p++) if (p != k) cyc(1, p, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0, 1);
            chk(int'(victim_idx) == k, "R1 only unread page", int'(victim_idx), k);
        end

        // R2 / R3: write all, tick, read all but k -> k is the lone modified-only page
        for (int p = 0; p < N; p++) cyc(0, 0, 1, p, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk(victim_dirty == 1'b1, "R2 write sets modified", int'(victim_dirty), 1);
        for (int k = 0; k < N; k++) begin
            cyc(0, 0, 0, 0, 1, 0);
            cyc(0, 0, 0, 0, 0, 1);
            chk(victim_dirty == 1'b1, "R3 tick keeps modified", int'(victim_dirty), 1);
            for (int p = 0; p < N; p++) if (p != k) cyc(1, p, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0, 1);
            chk(int'(victim_idx) == k, "R3 only cleared page", int'(victim_idx), k);
        end

        // R4: tick plus access to k, then read all but j -> j is the lone cold page
        do_reset();
        for (int k = 0; k < N; k++) begin
            int j = (k + 3) % N;
            cyc(k[0], k, !k[0], k, 1, 0);
            for (int p = 0; p < N; p++) if (p != k && p != j) cyc(1, p, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0, 1);
            chk(int'(victim_idx) == j, "R4 access beats tick", int'(victim_idx), j);
        end

        // R8: request in same cycle as read of the only cold page
        do_reset();
        for (int p = 1; p < N; p++) cyc(1, p, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 1);
        chk(int'(victim_idx) == 0, "R8 pre-update flags", int'(victim_idx), 0);

        // mixed random traffic
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            bit rv, wv, tk, rq;
            seed = seed * 32'd1103515245 + 32'd12345;
            rv = seed[20]; wv = seed[21] & seed[22];
            tk = (seed[25:23] == 3'd0);
            rq = seed[26];
            cyc(rv, int'(seed[29:27]), wv, int'(seed[18:16]), tk, rq);
        end
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule